// File: doc/BRIEF.md
# Audio Serial Port Clock Master Generator

This block sits between a master clock and two audio serial ports, a receive-side
port and a transmit-side port. A three-bit mode word decides which of the two ports,
if any, is clock master. The master port gets a bit clock and a frame clock made by
integer division of the master clock. The other port is a slave: its bit and frame
clock outputs pass through the clocks supplied from outside. One divider chain is
shared and its outputs go to one port only, so two masters cannot exist at once.

The mode code picks the oversampling ratio of the master: 256, 512 or 768 master
clock periods per frame. Every frame holds 64 bit clocks. One further code selects
matched-phase operation, which keeps both ports on external clocks and raises an
indication output. A change of the mode word restarts the divider cleanly at the
next master clock edge, so the new master clocks always begin with a full low phase.

Top module: `asp_clk_master`

## Requirements
- R1: Mode 3'b000: both ports carry their external bit and frame clocks unchanged, and `phase_match` is low.
- R2: Modes 3'b001, 3'b010 and 3'b011 make the output port master with a bit clock period of 12, 8 and 4 `mclk` cycles, each half high and half low. The input port carries its external clocks.
- R3: Modes 3'b101, 3'b110 and 3'b111 make the input port master with a bit clock period of 12, 8 and 4 `mclk` cycles, each half high and half low. The output port carries its external clocks.
- R4: Mode 3'b100: `phase_match` is high, and both ports carry their external clocks.
- R5: The master frame clock spans 64 bit clock periods. It is low for the first 32 and high for the next 32, counted from the divider start.
- R6: The master frame clock changes only in the `mclk` cycle in which the master bit clock falls.
- R7: After a divider start, the master bit clock is low for the first half period and high for the second.
- R8: At the first `mclk` edge where `mode_sel` differs from the mode held since the previous edge, the divider restarts: both generated clocks go low and the new mode takes effect at that edge.
- R9: `rst` is synchronous and active high. While it is sampled high, the generated clocks are held low and the dividers are held at their start.
- R10: Port roles and `phase_match` follow `mode_sel` as sampled at the last `mclk` edge. A change between edges has no effect on the ports until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all state is clocked on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Mode word selecting master port, ratio or matched-phase |
| in_ext_sclk | input | 1 | External bit clock for the input port |
| in_ext_lrclk | input | 1 | External frame clock for the input port |
| out_ext_sclk | input | 1 | External bit clock for the output port |
| out_ext_lrclk | input | 1 | External frame clock for the output port |
| in_sclk | output | 1 | Bit clock delivered to the input port |
| in_lrclk | output | 1 | Frame clock delivered to the input port |
| out_sclk | output | 1 | Bit clock delivered to the output port |
| out_lrclk | output | 1 | Frame clock delivered to the output port |
| phase_match | output | 1 | High while matched-phase mode is in force |

## Verification
The generated clocks and `phase_match` come from registers. They change at a rising
`mclk` edge, and the bench samples them at the following falling edge against a model
that counts the edges since the last restart. The slave pass-through is combinational
but steered by the registered mode, so it is checked in the same half cycle in which
the external clocks were driven. Role changes are checked one nanosecond after a mode
change and again after the next edge, which separates R10 from R8.

// File: rtl/asp_clk_pkg.sv
package asp_clk_pkg;

    // Width of the bit clock divide value (largest divide is 12)
    localparam int SDIV_W = 4;

    localparam logic [SDIV_W-1:0] SDIV_X768 = SDIV_W'(12);
    localparam logic [SDIV_W-1:0] SDIV_X512 = SDIV_W'(8);
    localparam logic [SDIV_W-1:0] SDIV_X256 = SDIV_W'(4);

    typedef enum logic [1:0] {
        ROLE_NONE       = 2'd0,
        ROLE_OUT_MASTER = 2'd1,
        ROLE_PHASE      = 2'd2,
        ROLE_IN_MASTER  = 2'd3
    } clk_role_e;

    typedef struct packed {
        clk_role_e         role;
        logic [SDIV_W-1:0] sdiv;
    } mode_cfg_t;

    // Ratio code in the low two mode bits -> master clocks per bit clock
    function automatic logic [SDIV_W-1:0] ratio_sdiv(input logic [1:0] code);
        logic [SDIV_W-1:0] d;
        case (code)
            2'b01:   d = SDIV_X768;
            2'b10:   d = SDIV_X512;
            2'b11:   d = SDIV_X256;
            default: d = '0;
        endcase
        return d;
    endfunction

    function automatic mode_cfg_t decode_mode(input logic [2:0] m);
        mode_cfg_t c;
        c.sdiv = ratio_sdiv(m[1:0]);
        if (m[1:0] == 2'b00) begin
            c.role = m[2] ? ROLE_PHASE : ROLE_NONE;
        end else begin
            c.role = m[2] ? ROLE_IN_MASTER : ROLE_OUT_MASTER;
        end
        return c;
    endfunction

    function automatic logic role_is_master(input clk_role_e r);
        return (r == ROLE_IN_MASTER) || (r == ROLE_OUT_MASTER);
    endfunction

endpackage

// File: rtl/asp_mode_ctrl.sv
module asp_mode_ctrl
    import asp_clk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_in,
    output mode_cfg_t  cfg,
    output logic       restart,
    output logic       run
);

    logic [2:0] mode_q;

    always_ff @(posedge clk) begin
        mode_q <= mode_in;
    end

    // Restart on reset or on any difference from the mode held last edge
    always_comb begin
        restart = rst || (mode_in != mode_q);
        cfg     = decode_mode(mode_q);
        run     = role_is_master(cfg.role);
    end

endmodule

// File: rtl/asp_clk_divider.sv
module asp_clk_divider
    import asp_clk_pkg::*;
#(
    parameter int FRAME_SCLKS = 64
) (
    input  logic              clk,
    input  logic              clear,
    input  logic              run,
    input  logic [SDIV_W-1:0] sdiv,
    output logic              sclk,
    output logic              lrclk
);

    localparam int BIT_W      = $clog2(FRAME_SCLKS);
    localparam int HALF_FRAME = FRAME_SCLKS / 2;

    logic [SDIV_W-1:0] sub_q, sub_n;
    logic [BIT_W-1:0]  bit_q, bit_n;
    logic              sub_last;
    logic              sclk_q, lr_q;

    always_comb begin
        sub_last = (sub_q == (sdiv - SDIV_W'(1)));
        sub_n    = sub_last ? '0 : sub_q + SDIV_W'(1);
        if (!sub_last) begin
            bit_n = bit_q;
        end else if (bit_q == BIT_W'(FRAME_SCLKS - 1)) begin
            bit_n = '0;
        end else begin
            bit_n = bit_q + BIT_W'(1);
        end
    end

    // Outputs are registered from the next counter state, so they never glitch
    always_ff @(posedge clk) begin
        if (clear || !run) begin
            sub_q  <= '0;
            bit_q  <= '0;
            sclk_q <= 1'b0;
            lr_q   <= 1'b0;
        end else begin
            sub_q  <= sub_n;
            bit_q  <= bit_n;
            sclk_q <= (sub_n >= (sdiv >> 1));
            lr_q   <= (bit_n >= BIT_W'(HALF_FRAME));
        end
    end

    assign sclk  = sclk_q;
    assign lrclk = lr_q;

endmodule

// File: rtl/asp_port_route.sv
module asp_port_route (
    input  logic is_master,
    input  logic gen_sclk,
    input  logic gen_lrclk,
    input  logic ext_sclk,
    input  logic ext_lrclk,
    output logic port_sclk,
    output logic port_lrclk
);

    always_comb begin
        port_sclk  = is_master ? gen_sclk  : ext_sclk;
        port_lrclk = is_master ? gen_lrclk : ext_lrclk;
    end

endmodule

// File: rtl/asp_clk_master.sv
module asp_clk_master
    import asp_clk_pkg::*;
#(
    parameter int FRAME_SCLKS = 64
) (
    input  logic       mclk,
    input  logic       rst,
    input  logic [2:0] mode_sel,
    input  logic       in_ext_sclk,
    input  logic       in_ext_lrclk,
    input  logic       out_ext_sclk,
    input  logic       out_ext_lrclk,
    output logic       in_sclk,
    output logic       in_lrclk,
    output logic       out_sclk,
    output logic       out_lrclk,
    output logic       phase_match
);

    localparam int NPORT   = 2;
    localparam int PORT_IN = 0;
    localparam int PORT_OUT = 1;

    mode_cfg_t  cfg;
    clk_role_e  role_q;
    logic       restart;
    logic       run;
    logic       gen_sclk;
    logic       gen_lrclk;

    logic [NPORT-1:0] sel_master;
    logic [NPORT-1:0] ext_sclk_v, ext_lr_v;
    logic [NPORT-1:0] prt_sclk_v, prt_lr_v;

    asp_mode_ctrl i_mode (
        .clk     (mclk),
        .rst     (rst),
        .mode_in (mode_sel),
        .cfg     (cfg),
        .restart (restart),
        .run     (run)
    );

    assign role_q = cfg.role;

    asp_clk_divider #(.FRAME_SCLKS(FRAME_SCLKS)) i_div (
        .clk   (mclk),
        .clear (restart),
        .run   (run),
        .sdiv  (cfg.sdiv),
        .sclk  (gen_sclk),
        .lrclk (gen_lrclk)
    );

    assign sel_master[PORT_IN]  = (role_q == ROLE_IN_MASTER);
    assign sel_master[PORT_OUT] = (role_q == ROLE_OUT_MASTER);
    assign ext_sclk_v = {out_ext_sclk, in_ext_sclk};
    assign ext_lr_v   = {out_ext_lrclk, in_ext_lrclk};

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
        asp_port_route i_route (
            .is_master  (sel_master[gi]),
            .gen_sclk   (gen_sclk),
            .gen_lrclk  (gen_lrclk),
            .ext_sclk   (ext_sclk_v[gi]),
            .ext_lrclk  (ext_lr_v[gi]),
            .port_sclk  (prt_sclk_v[gi]),
            .port_lrclk (prt_lr_v[gi])
        );
    end

    assign in_sclk     = prt_sclk_v[PORT_IN];
    assign in_lrclk    = prt_lr_v[PORT_IN];
    assign out_sclk    = prt_sclk_v[PORT_OUT];
    assign out_lrclk   = prt_lr_v[PORT_OUT];
    assign phase_match = (role_q == ROLE_PHASE);

endmodule

// File: rtl/asp_clk_master_chk.sv
module asp_clk_master_chk
    import asp_clk_pkg::*;
(
    input logic       mclk,
    input logic       rst,
    input logic [2:0] mode_sel,
    input clk_role_e  role_q,
    input logic       restart,
    input logic       gen_sclk,
    input logic       gen_lrclk,
    input logic       in_ext_sclk,
    input logic       in_ext_lrclk,
    input logic       out_ext_sclk,
    input logic       out_ext_lrclk,
    input logic       in_sclk,
    input logic       in_lrclk,
    input logic       out_sclk,
    input logic       out_lrclk,
    input logic       phase_match
);

    // R1 / R4: no master -> both ports are slaves
    a_r1_both_slave: assert property (@(posedge mclk) disable iff (rst)
        (role_q == ROLE_NONE || role_q == ROLE_PHASE) |->
            (in_sclk == in_ext_sclk && in_lrclk == in_ext_lrclk &&
             out_sclk == out_ext_sclk && out_lrclk == out_ext_lrclk));

    // R2: output master drives generated clocks, input port stays slave
    a_r2_out_master: assert property (@(posedge mclk) disable iff (rst)
        (role_q == ROLE_OUT_MASTER) |->
            (out_sclk == gen_sclk && out_lrclk == gen_lrclk &&
             in_sclk == in_ext_sclk && in_lrclk == in_ext_lrclk));

    // R3: input master drives generated clocks, output port stays slave
    a_r3_in_master: assert property (@(posedge mclk) disable iff (rst)
        (role_q == ROLE_IN_MASTER) |->
            (in_sclk == gen_sclk && in_lrclk == gen_lrclk &&
             out_sclk == out_ext_sclk && out_lrclk == out_ext_lrclk));

    // R4 / R10: indication follows the mode sampled at the previous edge
    a_r4_phase_flag: assert property (@(posedge mclk) disable iff (rst)
        phase_match == ($past(mode_sel) == 3'b100));

    // R6: frame clock moves only with a falling bit clock
    a_r6_lr_on_fall: assert property (@(posedge mclk) disable iff (rst)
        (!$past(restart) && $changed(gen_lrclk)) |-> $fell(gen_sclk));

    // R8: a restart leaves both generated clocks low
    a_r8_restart_low: assert property (@(posedge mclk) disable iff (rst)
        restart |=> (!gen_sclk && !gen_lrclk));

    // R9: leaving reset, generated clocks are still low
    a_r9_reset_low: assert property (@(posedge mclk) disable iff (rst)
        $fell(rst) |-> (!gen_sclk && !gen_lrclk));

endmodule

bind asp_clk_master asp_clk_master_chk i_chk (
    .mclk          (mclk),
    .rst           (rst),
    .mode_sel      (mode_sel),
    .role_q        (role_q),
    .restart       (restart),
    .gen_sclk      (gen_sclk),
    .gen_lrclk     (gen_lrclk),
    .in_ext_sclk   (in_ext_sclk),
    .in_ext_lrclk  (in_ext_lrclk),
    .out_ext_sclk  (out_ext_sclk),
    .out_ext_lrclk (out_ext_lrclk),
    .in_sclk       (in_sclk),
    .in_lrclk      (in_lrclk),
    .out_sclk      (out_sclk),
    .out_lrclk     (out_lrclk),
    .phase_match   (phase_match)
);

// File: tb/test_asp_clk_master.sv
module test_asp_clk_master;

    logic       mclk = 1'b0;
    logic       rst_drv;
    logic [2:0] mode_drv;
    logic       ie_s, ie_l, oe_s, oe_l;
    logic       in_sclk, in_lrclk, out_sclk, out_lrclk, phase_match;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 mclk = ~mclk;   // 125 MHz

    asp_clk_master i_asp_clk_master (
        .mclk          (mclk),
        .rst           (rst_drv),
        .mode_sel      (mode_drv),
        .in_ext_sclk   (ie_s),
        .in_ext_lrclk  (ie_l),
        .out_ext_sclk  (oe_s),
        .out_ext_lrclk (oe_l),
        .in_sclk       (in_sclk),
        .in_lrclk      (in_lrclk),
        .out_sclk      (out_sclk),
        .out_lrclk     (out_lrclk),
        .phase_match   (phase_match)
    );

    // Reference: edges since the last restart, and the mode held since the last edge
    int         n_ref;
    logic [2:0] m_ref;
    bit         was_rst;

    always @(posedge mclk) begin
        if (rst_drv || mode_drv != m_ref) n_ref <= 0;
        else                              n_ref <= n_ref + 1;
        m_ref   <= mode_drv;
        was_rst <= rst_drv;
    end

    function automatic int bsdiv(input logic [2:0] m);
        case (m[1:0])
            2'b01:   return 12;
            2'b10:   return 8;
            2'b11:   return 4;
            default: return 0;
        endcase
    endfunction

    function automatic bit exp_sclk(input int n, input int d);
        return (n % d) >= (d / 2);
    endfunction

    function automatic bit exp_lr(input int n, input int d);
        return ((n / d) % 64) >= 32;
    endfunction

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b (t=%0t)", req, what, got, exp, $time);
        end
    endtask

    // Previous master-port sample for R6
    bit pv_ok = 1'b0;
    bit pv_s, pv_l;

    task automatic verify();
        int d;
        bit gs, gl, ms, ml;
        string rs, rl, rp;
        d  = bsdiv(m_ref);
        gs = (d == 0) ? 1'b0 : exp_sclk(n_ref, d);
        gl = (d == 0) ? 1'b0 : exp_lr(n_ref, d);
        rs = (m_ref[2]) ? "R3" : "R2";
        rl = "R5";
        if (was_rst) begin rs = "R9"; rl = "R9"; end
        else if (n_ref == 0) begin rs = "R8"; rl = "R8"; end
        else if (n_ref < d) rs = "R7";
        rp = (m_ref == 3'b100) ? "R4" : "R1";
        case (m_ref)
            3'b001, 3'b010, 3'b011: begin
                chk(out_sclk, gs, rs, "out_sclk");
                chk(out_lrclk, gl, rl, "out_lrclk");
                chk(in_sclk, ie_s, "R2", "in_sclk slave");
                chk(in_lrclk, ie_l, "R2", "in_lrclk slave");
                ms = out_sclk; ml = out_lrclk;
            end
            3'b101, 3'b110, 3'b111: begin
                chk(in_sclk, gs, rs, "in_sclk");
                chk(in_lrclk, gl, rl, "in_lrclk");
                chk(out_sclk, oe_s, "R3", "out_sclk slave");
                chk(out_lrclk, oe_l, "R3", "out_lrclk slave");
                ms = in_sclk; ml = in_lrclk;
            end
            default: begin
                chk(in_sclk, ie_s, rp, "in_sclk pass");
                chk(in_lrclk, ie_l, rp, "in_lrclk pass");
                chk(out_sclk, oe_s, rp, "out_sclk pass");
                chk(out_lrclk, oe_l, rp, "out_lrclk pass");
                ms = 1'b0; ml = 1'b0;
            end
        endcase
        chk(phase_match, (m_ref == 3'b100), rp, "phase_match");
        if (d != 0 && !was_rst && n_ref > 0 && pv_ok && ml != pv_l) begin
            chk(pv_s, 1'b1, "R6", "sclk high before frame edge");
            chk(ms, 1'b0, "R6", "sclk low at frame edge");
        end
        pv_ok = (d != 0) && !was_rst;
        pv_s  = ms;
        pv_l  = ml;
    endtask

    task automatic cycle();
        @(negedge mclk);
        verify();
        ie_s = 1'($urandom); ie_l = 1'($urandom);
        oe_s = 1'($urandom); oe_l = 1'($urandom);
    endtask

    task automatic run_mode(input logic [2:0] m, input int len);
        mode_drv = m;
        for (int k = 0; k < len; k++) cycle();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_drv  = 1'b1;
        mode_drv = 3'b011;
        ie_s = 0; ie_l = 0; oe_s = 1; oe_l = 1;
        // R9: held in reset with an output-master mode selected
        for (int k = 0; k < 6; k++) cycle();
        @(negedge mclk);
        rst_drv = 1'b0;

        // Directed sweep of every mode over two full frames of the slowest ratio
        run_mode(3'b000, 40);
        run_mode(3'b001, 1600);
        run_mode(3'b010, 1100);
        run_mode(3'b011, 600);
        run_mode(3'b100, 40);
        run_mode(3'b101, 1600);
        run_mode(3'b110, 1100);
        run_mode(3'b111, 600);

        // R10: a mode change between edges does not reach the ports early
        run_mode(3'b000, 4);
        @(negedge mclk);
        oe_s = 1'b1; oe_l = 1'b1;
        mode_drv = 3'b011;
        #1;
        chk(out_sclk, 1'b1, "R10", "out_sclk before edge");
        chk(phase_match, 1'b0, "R10", "phase_match before edge");
        @(posedge mclk);
        #1;
        chk(out_sclk, 1'b0, "R8", "out_sclk after edge");
        chk(out_lrclk, 1'b0, "R8", "out_lrclk after edge");
        pv_ok = 1'b0;
        run_mode(3'b011, 50);

        // R8: a mode change mid-frame between two master ratios
        run_mode(3'b001, 400);
        run_mode(3'b111, 30);
        run_mode(3'b101, 30);

        // R9: reset in the middle of an active master mode
        @(negedge mclk);
        rst_drv = 1'b1;
        for (int k = 0; k < 3; k++) cycle();
        rst_drv = 1'b0;
        run_mode(3'b101, 200);

        // Random segments, some very short
        for (int s = 0; s < 40; s++) begin
            int len;
            len = ($urandom % 3 == 0) ? 1 + int'($urandom % 20) : 100 + int'($urandom % 1500);
            if ($urandom % 8 == 0) begin
                rst_drv = 1'b1;
                cycle();
                rst_drv = 1'b0;
            end
            run_mode(3'($urandom), len);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge mclk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule